// File: doc/BRIEF.md
# Interval Timer Bus Interface and Latch Unit

This block is the byte-wide host port of a three-channel interval timer. It decodes control words written to the control address and hands each channel its counting mode, byte-access type and BCD flag. It assembles the 16-bit initial value from one or two data-byte writes and announces each completed value with a one-cycle load pulse. The counting itself lives in separate counter-channel blocks. Those blocks report back to this unit a live 16-bit count and an output level for each channel.

On the read side the unit serves data-port reads from three sources, in a fixed priority: a frozen status byte, then a frozen count snapshot, then the live count. A snapshot is taken either by a per-channel count-latch command or by a read-back command, which can freeze count, status or both on several channels in one write. A snapshot that has not yet been read is never replaced by a newer one.

Read data is combinational while `rd_en` is high. Every side effect of a read or write (sequencer steps, latch release, configuration updates) takes effect at the rising clock edge that ends that cycle. `init_val`, `load_pulse` and `ctrl_pulse` are registered, so they appear in the cycle after the write.

Top module: `ivt_regif`

## Requirements
- R1: After reset every channel has access type 3 (low then high byte), mode 0, BCD flag 0, no pending latches, no load or control pulse, and both byte sequencers start at the low byte.
- R2: A write to address 3 whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are nonzero sets that channel's access type from bits 5:4, its mode from bits 3:1 and its BCD flag from bit 0. It pulses that channel's `ctrl_pulse` for one cycle and returns both of its byte sequencers to the low byte.
- R3: With access type 1 (low byte only), a data write loads the initial value {8'h00, byte} and pulses `load_pulse` in the next cycle.
- R4: With access type 2 (high byte only), a data write loads the initial value {byte, 8'h00}.
- R5: With access type 3, the first data write only stores the byte and does not load. The second loads {second, first}. A control write between the two discards the stored first byte.
- R6: A count-latch command (address 3, bits 5:4 = 0) freezes the channel's live count at that cycle. Data reads then return the frozen bytes in the channel's access pattern (low only, high only, or low then high) regardless of later live changes, and the latch is released after the last byte.
- R7: A count-latch or status-latch request to a channel that still holds an unread latch of the same kind is ignored.
- R8: A read-back command (bits 7:6 = 3) acts on each channel whose select bit is set (bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2). It latches the count when bit 5 is 0 and the status when bit 4 is 0.
- R9: The status byte is {output level, 1'b0, access type[1:0], mode[2:0], BCD flag}, taken at the cycle of the command.
- R10: A data read returns the latched status first and clears it. Failing that it returns a latched count byte, and failing that a live count byte.
- R11: Live reads return the low byte for access type 1 and the high byte for type 2. For type 3 they alternate low, high, low, and so on.
- R12: A read of address 3 returns 8'hFF and changes no state.
- R13: A count-latch command leaves the channel's mode, access type and BCD flag unchanged and gives no `ctrl_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0..2 data ports, 3 control |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| live_cnt | input | 48 | Live count of each channel, channel i in bits 16i+15:16i |
| ch_out | input | 3 | Output level of each channel |
| cfg_mode | output | 9 | Mode of each channel, 3 bits per channel |
| cfg_acc | output | 6 | Access type of each channel, 2 bits per channel |
| cfg_bcd | output | 3 | BCD flag of each channel |
| init_val | output | 48 | Last loaded initial value of each channel |
| load_pulse | output | 3 | One-cycle pulse when a channel's initial value is loaded |
| ctrl_pulse | output | 3 | One-cycle pulse when a channel's control word is written |

## Verification
The bench targets the two-byte write sequencer being reset by a control write. A design that ignored this would load a value built from a stale low byte. It checks that a second latch command while the first is unread keeps the first snapshot, where a faulty design would return the newer live value. Read-back with both kinds selected must give status, then count, then live. A wrong priority or a latch never released would repeat the status or count byte. Further cases cover the status bit positions, a high-only latch returning the high byte, and a control-address read that must leave the live low/high sequencer where it was.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL    = 2'd3;

  function automatic logic [7:0] pack_status(logic out_lvl, acc_e acc,
                                              logic [2:0] mode, logic bcd);
    return {out_lvl, 1'b0, acc, mode, bcd};
  endfunction

endpackage

// File: rtl/ivt_decode.sv
module ivt_decode #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  localparam int AW = 2
) (
  input  logic [AW-1:0]  addr,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [DW-1:0]  wdata,
  output logic [NCH-1:0] ctl_we,
  output logic [NCH-1:0] data_we,
  output logic [NCH-1:0] data_re,
  output logic [NCH-1:0] cnt_req,
  output logic [NCH-1:0] st_req
);
  import ivt_pkg::*;

  logic ctl_wr;
  logic rb_cmd;
  logic acc_zero;

  always_comb begin
    ctl_wr   = wr_en && (addr == CTRL_ADDR);
    rb_cmd   = ctl_wr && (wdata[7:6] == RB_SEL);
    acc_zero = (wdata[5:4] == ACC_LATCH);
    for (int i = 0; i < NCH; i++) begin
      ctl_we[i]  = ctl_wr && (wdata[7:6] == 2'(i)) && !acc_zero;
      data_we[i] = wr_en && (addr == 2'(i));
      data_re[i] = rd_en && (addr == 2'(i));
      cnt_req[i] = (ctl_wr && (wdata[7:6] == 2'(i)) && acc_zero) ||
                   (rb_cmd && wdata[i+1] && !wdata[5]);
      st_req[i]  = rb_cmd && wdata[i+1] && !wdata[4];
    end
  end

endmodule

// File: rtl/ivt_chan.sv
module ivt_chan #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          data_we,
  input  logic          data_re,
  input  logic          cnt_req,
  input  logic          st_req,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] live_cnt,
  input  logic          out_lvl,
  output logic [DW-1:0] rd_byte,
  output logic [2:0]    cfg_mode,
  output logic [1:0]    cfg_acc,
  output logic          cfg_bcd,
  output logic [CW-1:0] init_val,
  output logic          load_pulse,
  output logic          ctrl_pulse
);
  import ivt_pkg::*;

  logic [2:0]    mode_q, mode_n;
  acc_e          acc_q, acc_n;
  logic          bcd_q, bcd_n;
  logic          wpend_q, wpend_n;
  logic [DW-1:0] wlow_q, wlow_n;
  logic          rhi_q, rhi_n;
  logic          cl_vld_q, cl_vld_n;
  logic          cl_hi_q, cl_hi_n;
  logic          cl_two_q, cl_two_n;
  logic [CW-1:0] cl_val_q, cl_val_n;
  logic          sl_vld_q, sl_vld_n;
  logic [DW-1:0] sl_val_q, sl_val_n;
  logic [CW-1:0] init_q, init_n;
  logic          load_q, load_n;
  logic          ctrl_q, ctrl_n;

  // read byte selection: status, then frozen count, then live count
  always_comb begin
    if (sl_vld_q) begin
      rd_byte = sl_val_q;
    end else if (cl_vld_q) begin
      rd_byte = cl_hi_q ? cl_val_q[CW-1:DW] : cl_val_q[DW-1:0];
    end else begin
      unique case (acc_q)
        ACC_HI:   rd_byte = live_cnt[CW-1:DW];
        ACC_WORD: rd_byte = rhi_q ? live_cnt[CW-1:DW] : live_cnt[DW-1:0];
        default:  rd_byte = live_cnt[DW-1:0];
      endcase
    end
  end

  // next-state logic
  always_comb begin
    mode_n   = mode_q;
    acc_n    = acc_q;
    bcd_n    = bcd_q;
    wpend_n  = wpend_q;
    wlow_n   = wlow_q;
    rhi_n    = rhi_q;
    cl_vld_n = cl_vld_q;
    cl_hi_n  = cl_hi_q;
    cl_two_n = cl_two_q;
    cl_val_n = cl_val_q;
    sl_vld_n = sl_vld_q;
    sl_val_n = sl_val_q;
    init_n   = init_q;
    load_n   = 1'b0;
    ctrl_n   = 1'b0;

    if (ctl_we) begin
      mode_n  = wdata[3:1];
      acc_n   = acc_e'(wdata[5:4]);
      bcd_n   = wdata[0];
      wpend_n = 1'b0;
      rhi_n   = 1'b0;
      ctrl_n  = 1'b1;
    end

    if (data_we) begin
      unique case (acc_q)
        ACC_LO: begin
          init_n = {{DW{1'b0}}, wdata};
          load_n = 1'b1;
        end
        ACC_HI: begin
          init_n = {wdata, {DW{1'b0}}};
          load_n = 1'b1;
        end
        ACC_WORD: begin
          if (wpend_q) begin
            init_n  = {wdata, wlow_q};
            load_n  = 1'b1;
            wpend_n = 1'b0;
          end else begin
            wlow_n  = wdata;
            wpend_n = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (data_re) begin
      if (sl_vld_q) begin
        sl_vld_n = 1'b0;
      end else if (cl_vld_q) begin
        if (cl_two_q && !cl_hi_q) begin
          cl_hi_n = 1'b1;
        end else begin
          cl_vld_n = 1'b0;
        end
      end else if (acc_q == ACC_WORD) begin
        rhi_n = !rhi_q;
      end
    end

    if (cnt_req && !cl_vld_q) begin
      cl_vld_n = 1'b1;
      cl_val_n = live_cnt;
      cl_two_n = (acc_q == ACC_WORD);
      cl_hi_n  = (acc_q == ACC_HI);
    end

    if (st_req && !sl_vld_q) begin
      sl_vld_n = 1'b1;
      sl_val_n = pack_status(out_lvl, acc_q, mode_q, bcd_q);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 3'd0;
      acc_q    <= ACC_WORD;
      bcd_q    <= 1'b0;
      wpend_q  <= 1'b0;
      wlow_q   <= '0;
      rhi_q    <= 1'b0;
      cl_vld_q <= 1'b0;
      cl_hi_q  <= 1'b0;
      cl_two_q <= 1'b0;
      cl_val_q <= '0;
      sl_vld_q <= 1'b0;
      sl_val_q <= '0;
      init_q   <= '0;
      load_q   <= 1'b0;
      ctrl_q   <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      acc_q    <= acc_n;
      bcd_q    <= bcd_n;
      wpend_q  <= wpend_n;
      wlow_q   <= wlow_n;
      rhi_q    <= rhi_n;
      cl_vld_q <= cl_vld_n;
      cl_hi_q  <= cl_hi_n;
      cl_two_q <= cl_two_n;
      cl_val_q <= cl_val_n;
      sl_vld_q <= sl_vld_n;
      sl_val_q <= sl_val_n;
      init_q   <= init_n;
      load_q   <= load_n;
      ctrl_q   <= ctrl_n;
    end
  end

  assign cfg_mode   = mode_q;
  assign cfg_acc    = acc_q;
  assign cfg_bcd    = bcd_q;
  assign init_val   = init_q;
  assign load_pulse = load_q;
  assign ctrl_pulse = ctrl_q;

endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  localparam int AW = 2
) (
  input  logic [AW-1:0]     addr,
  input  logic [NCH*DW-1:0] ch_bytes,
  output logic [DW-1:0]     rdata
);

  always_comb begin
    rdata = {DW{1'b1}};
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) rdata = ch_bytes[i*DW +: DW];
    end
  end

endmodule

// File: rtl/ivt_regif.sv
module ivt_regif #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  localparam int CW = 2 * DW,
  localparam int AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NCH*CW-1:0] live_cnt,
  input  logic [NCH-1:0]    ch_out,
  output logic [NCH*3-1:0]  cfg_mode,
  output logic [NCH*2-1:0]  cfg_acc,
  output logic [NCH-1:0]    cfg_bcd,
  output logic [NCH*CW-1:0] init_val,
  output logic [NCH-1:0]    load_pulse,
  output logic [NCH-1:0]    ctrl_pulse
);

  logic [NCH-1:0]    ctl_we, data_we, data_re, cnt_req, st_req;
  logic [NCH*DW-1:0] ch_bytes;

  ivt_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .ctl_we  (ctl_we),
    .data_we (data_we),
    .data_re (data_re),
    .cnt_req (cnt_req),
    .st_req  (st_req)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ivt_chan #(.DW(DW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (ctl_we[g]),
      .data_we    (data_we[g]),
      .data_re    (data_re[g]),
      .cnt_req    (cnt_req[g]),
      .st_req     (st_req[g]),
      .wdata      (wdata),
      .live_cnt   (live_cnt[g*CW +: CW]),
      .out_lvl    (ch_out[g]),
      .rd_byte    (ch_bytes[g*DW +: DW]),
      .cfg_mode   (cfg_mode[g*3 +: 3]),
      .cfg_acc    (cfg_acc[g*2 +: 2]),
      .cfg_bcd    (cfg_bcd[g]),
      .init_val   (init_val[g*CW +: CW]),
      .load_pulse (load_pulse[g]),
      .ctrl_pulse (ctrl_pulse[g])
    );
  end

  ivt_rdmux #(.NCH(NCH), .DW(DW)) u_mux (
    .addr     (addr),
    .ch_bytes (ch_bytes),
    .rdata    (rdata)
  );

endmodule

// File: rtl/ivt_regif_chk.sv
module ivt_regif_chk #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  localparam int AW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    wdata,
  input logic [DW-1:0]    rdata,
  input logic [NCH*3-1:0] cfg_mode,
  input logic [NCH*2-1:0] cfg_acc,
  input logic [NCH-1:0]   load_pulse,
  input logic [NCH-1:0]   ctrl_pulse
);

  // R12
  ctl_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> (rdata == {DW{1'b1}}));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R3
    load_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse[g] |-> $past(wr_en && addr == AW'(g)));

    // R2
    cfg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[7:6] == 2'(g) && wdata[5:4] != 2'd0)
      |=> (cfg_mode[g*3 +: 3] == $past(wdata[3:1]) &&
           cfg_acc[g*2 +: 2] == $past(wdata[5:4]) && ctrl_pulse[g]));

    // R13
    latch_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[5:4] == 2'd0)
      |=> ($stable(cfg_mode[g*3 +: 3]) && $stable(cfg_acc[g*2 +: 2]) && !ctrl_pulse[g]));

    // R1
    acc_never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_acc[g*2 +: 2] != 2'd0);
  end

endmodule

bind ivt_regif ivt_regif_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .cfg_mode   (cfg_mode),
  .cfg_acc    (cfg_acc),
  .load_pulse (load_pulse),
  .ctrl_pulse (ctrl_pulse)
);

// File: tb/ivt_regif_tb.sv
module ivt_regif_tb;
  localparam int PER = 10;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic        wr_en, rd_en;
  logic [7:0]  wdata, rdata;
  logic [15:0] live [NCH];
  logic [47:0] live_cnt;
  logic [2:0]  ch_out;
  logic [8:0]  cfg_mode;
  logic [5:0]  cfg_acc;
  logic [2:0]  cfg_bcd;
  logic [47:0] init_val;
  logic [2:0]  load_pulse, ctrl_pulse;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  assign live_cnt = {live[2], live[1], live[0]};

  always #(PER/2) clk = ~clk;

  ivt_regif u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .ch_out(ch_out),
    .cfg_mode(cfg_mode), .cfg_acc(cfg_acc), .cfg_bcd(cfg_bcd),
    .init_val(init_val), .load_pulse(load_pulse), .ctrl_pulse(ctrl_pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: write one byte
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  // driver: read one byte, expected value goes to the scoreboard
  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_load(input int ch, input logic [15:0] e, input string tag);
    check(load_pulse[ch] === 1'b1, {tag, " load pulse"}, int'(load_pulse[ch]), 1);
    check(init_val[ch*16 +: 16] === e, {tag, " init value"}, int'(init_val[ch*16 +: 16]), int'(e));
  endtask

  task automatic chk_cfg(input int ch, input logic [1:0] acc, input logic [2:0] mode,
                         input logic bcd, input string tag);
    check(cfg_acc[ch*2 +: 2] === acc, {tag, " access"}, int'(cfg_acc[ch*2 +: 2]), int'(acc));
    check(cfg_mode[ch*3 +: 3] === mode, {tag, " mode"}, int'(cfg_mode[ch*3 +: 3]), int'(mode));
    check(cfg_bcd[ch] === bcd, {tag, " bcd"}, int'(cfg_bcd[ch]), int'(bcd));
  endtask

  // monitor: compare each read against the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      #(PER/4);
      if (rd_en === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "scoreboard empty", int'(rdata), 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(rdata === e, t, int'(rdata), int'(e));
        end
      end
    end
  end

  initial begin
    #(PER * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    ch_out = '0;
    for (int i = 0; i < NCH; i++) live[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    for (int i = 0; i < NCH; i++) chk_cfg(i, 2'd3, 3'd0, 1'b0, "R1");
    check(load_pulse === 3'b000 && ctrl_pulse === 3'b000, "R1 pulses",
          int'({load_pulse, ctrl_pulse}), 0);
    live[0] = 16'h1234;
    rd(2'd0, 8'h34, "R1 live low first");
    rd(2'd0, 8'h12, "R11 live high second");

    // R2 control word: ch1, low-only, mode 2, bcd 1
    wr(2'd3, 8'h55);
    chk_cfg(1, 2'd1, 3'd2, 1'b1, "R2");
    check(ctrl_pulse[1] === 1'b1, "R2 ctrl pulse", int'(ctrl_pulse[1]), 1);
    // R3 low-only write
    wr(2'd1, 8'hAB);
    chk_load(1, 16'h00AB, "R3");
    live[1] = 16'hBEEF;
    rd(2'd1, 8'hEF, "R11 low-only read");
    rd(2'd1, 8'hEF, "R11 low-only no alternate");

    // R4 high-only: ch2, mode 3
    wr(2'd3, 8'hA6);
    chk_cfg(2, 2'd2, 3'd3, 1'b0, "R2 ch2");
    wr(2'd2, 8'h5C);
    chk_load(2, 16'h5C00, "R4");
    live[2] = 16'h7788;
    rd(2'd2, 8'h77, "R11 high-only read");

    // R5 two-byte: ch0, mode 2
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h11);
    check(load_pulse[0] === 1'b0, "R5 no load on first byte", int'(load_pulse[0]), 0);
    wr(2'd0, 8'h22);
    chk_load(0, 16'h2211, "R5");
    wr(2'd0, 8'h33);
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h44);
    check(load_pulse[0] === 1'b0, "R5 first byte after control", int'(load_pulse[0]), 0);
    wr(2'd0, 8'h55);
    chk_load(0, 16'h5544, "R5 sequencer restart");

    // R6/R7/R13 counter latch on ch0
    live[0] = 16'hA1B2;
    wr(2'd3, 8'h00);
    check(ctrl_pulse[0] === 1'b0, "R13 no ctrl pulse", int'(ctrl_pulse[0]), 0);
    chk_cfg(0, 2'd3, 3'd2, 1'b0, "R13");
    live[0] = 16'hCCDD;
    wr(2'd3, 8'h00);
    live[0] = 16'h0F0E;
    rd(2'd0, 8'hB2, "R6 latched low");
    rd(2'd0, 8'hA1, "R7 latched high kept");
    rd(2'd0, 8'h0E, "R6 released live low");
    rd(2'd0, 8'h0F, "R6 released live high");

    // R8/R9/R10 read-back of count and status on ch1 and ch2
    live[1] = 16'h1357; live[2] = 16'h2468; ch_out = 3'b110;
    wr(2'd3, 8'hCC);
    live[1] = 16'h9999; live[2] = 16'h0000; ch_out = 3'b000;
    rd(2'd1, 8'h95, "R9 status ch1");
    rd(2'd1, 8'h57, "R10 latched count after status");
    rd(2'd1, 8'h99, "R10 live after latches");
    rd(2'd2, 8'hA6, "R8 status ch2");
    rd(2'd2, 8'h24, "R8 high-only latched count");

    // R7 status-only read-back, second request ignored
    wr(2'd3, 8'hE2);
    ch_out[0] = 1'b1;
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'h34, "R7 status kept");
    rd(2'd0, 8'h0E, "R8 no count latched");
    // R12 control-address read, live sequencer untouched
    rd(2'd3, 8'hFF, "R12 reads all ones");
    rd(2'd0, 8'h0F, "R12 no side effect");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule